// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus interface of a parallel NOR flash array and interprets every write cycle the host issues. Each write arrives as one `wr_valid` pulse with an address and data word already captured from the bus strobes. The block walks the two-step unlock handshake and the command byte that follows it. When a sequence completes, it issues a single-cycle launch strobe to the program or erase engine. Address and data travel with the program and sector-erase strobes.

The block also holds the read-mode select. In array mode, reads go to the memory. In identification mode, the block itself answers reads from a small table: a manufacturer code, a device code and the boot lockout status. Any write that breaks a sequence drops the decoder back to its idle step. A write of F0 is the one exception: it always leaves identification mode. While the embedded engine reports busy, every write is ignored and leaves no trace.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `id_mode` is 0, all strobes are 0 and no partial sequence is pending. A lone A0 at 5555 followed by a data write launches nothing.
- R2: The writes AA@5555, 55@2AAA and A0@5555, followed by a fourth write, pulse `prog_go` in the cycle after that fourth write. `op_addr` and `op_data` then carry the fourth write's full address and data.
- R3: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA and 10@5555 pulse `chip_erase_go` in the cycle after the sixth write.
- R4: The same five-write prefix followed by 30 at any address pulses `sect_erase_go`. `op_addr` carries that sixth write's full address.
- R5: The same five-write prefix followed by 40@5555 pulses `lock_go`.
- R6: The writes AA@5555, 55@2AAA and 90@5555 set `id_mode` to 1 in the cycle after the third write. The writes AA@5555, 55@2AAA and F0@5555 clear it.
- R7: A write whose low data byte is F0, at any address and at any sequence step except the program data step, clears `id_mode` and returns the decoder to idle. On the program data step, F0 is program data, and `id_mode` is left unchanged.
- R8: A write whose low address bits or low data byte do not match the expected step returns the decoder to idle. The sequence must then restart from AA@5555.
- R9: Only address bits 15:0 and data bits 7:0 take part in command matching. Address bit 16 and data bits 15:8 are ignored.
- R10: While `busy` is 1, writes launch nothing, leave `id_mode` unchanged and do not advance or reset the sequence.
- R11: When `id_mode` is 1, `id_data` reads as follows:
  - address 0 returns MFR_CODE;
  - address 1 returns DEV_CODE;
  - address 2 returns `lock_status` in bit 0;
  - any other address returns 0.
  When `id_mode` is 0, `id_data` is 0. With the default parameters the output is combinational.
- R12: At most one launch strobe is high in any cycle, and each strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One write cycle is presented |
| wr_addr | input | ADDR_W (17) | Word address of the write |
| wr_data | input | DATA_W (16) | Data of the write |
| busy | input | 1 | Embedded program/erase engine active |
| lock_status | input | 1 | Current boot lockout state, reported in identification mode |
| rd_addr | input | ADDR_W (17) | Read address for identification data |
| prog_go | output | 1 | Launch word program |
| sect_erase_go | output | 1 | Launch sector erase |
| chip_erase_go | output | 1 | Launch chip erase |
| lock_go | output | 1 | Launch boot lockout enable |
| op_addr | output | ADDR_W (17) | Target address for program or sector erase |
| op_data | output | DATA_W (16) | Program data |
| id_mode | output | 1 | 1 = identification read mode, 0 = array read mode |
| id_data | output | ID_W (8) | Identification read data |

## Verification
Two decisions can land on the same write: the lone-F0 identification exit and the program data step. The bench enters identification mode, runs a program sequence and supplies 00F0 as the program data. A correct decoder launches the program with that data, and `id_mode` must stay 1. The converse case is an F0 that arrives partway through an erase prefix. It must clear `id_mode` and abort the prefix, and no erase may follow.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_KEY1,
      SQ_KEY2,
      SQ_PROG,
      SQ_EXT3,
      SQ_EXT4,
      SQ_EXT5
   } seq_step_t;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_PROG,
      OP_SECT,
      OP_CHIP,
      OP_LOCK,
      OP_ID_ON,
      OP_ID_OFF
   } op_kind_t;

   typedef struct packed {
      logic at_key1;
      logic at_key2;
      logic d_key1;
      logic d_key2;
      logic d_prog;
      logic d_ext;
      logic d_chip;
      logic d_sect;
      logic d_lock;
      logic d_id_on;
      logic d_exit;
   } cmd_hits_t;

   localparam logic [15:0] KEY1_ADDR = 16'h5555;
   localparam logic [15:0] KEY2_ADDR = 16'h2AAA;
   localparam logic [7:0]  KEY1_DATA = 8'hAA;
   localparam logic [7:0]  KEY2_DATA = 8'h55;
   localparam logic [7:0]  CMD_PROG  = 8'hA0;
   localparam logic [7:0]  CMD_EXT   = 8'h80;
   localparam logic [7:0]  CMD_CHIP  = 8'h10;
   localparam logic [7:0]  CMD_SECT  = 8'h30;
   localparam logic [7:0]  CMD_LOCK  = 8'h40;
   localparam logic [7:0]  CMD_IDON  = 8'h90;
   localparam logic [7:0]  CMD_EXIT  = 8'hF0;

endpackage

// File: rtl/cmd_matcher.sv
module cmd_matcher
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 16,
   parameter int CMP_ADDR_W = 16,
   parameter int CMP_DATA_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output cmd_hits_t         hits
);
   logic [CMP_ADDR_W-1:0] a_low;
   logic [CMP_DATA_W-1:0] d_low;

   assign a_low = addr[CMP_ADDR_W-1:0];
   assign d_low = data[CMP_DATA_W-1:0];

   function automatic logic a_is(input logic [CMP_ADDR_W-1:0] a, input logic [15:0] k);
      return a == CMP_ADDR_W'(k);
   endfunction

   function automatic logic d_is(input logic [CMP_DATA_W-1:0] d, input logic [7:0] k);
      return d == CMP_DATA_W'(k);
   endfunction

   always_comb begin
      hits.at_key1 = a_is(a_low, KEY1_ADDR);
      hits.at_key2 = a_is(a_low, KEY2_ADDR);
      hits.d_key1  = d_is(d_low, KEY1_DATA);
      hits.d_key2  = d_is(d_low, KEY2_DATA);
      hits.d_prog  = d_is(d_low, CMD_PROG);
      hits.d_ext   = d_is(d_low, CMD_EXT);
      hits.d_chip  = d_is(d_low, CMD_CHIP);
      hits.d_sect  = d_is(d_low, CMD_SECT);
      hits.d_lock  = d_is(d_low, CMD_LOCK);
      hits.d_id_on = d_is(d_low, CMD_IDON);
      hits.d_exit  = d_is(d_low, CMD_EXIT);
   end
endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
   import flash_cmd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      accept,
   input  cmd_hits_t hits,
   output op_kind_t  op
);
   seq_step_t step_q, step_d;

   always_comb begin
      step_d = step_q;
      op     = OP_NONE;
      if (accept) begin
         step_d = SQ_IDLE;
         unique case (step_q)
            SQ_IDLE: begin
               if (hits.at_key1 && hits.d_key1) step_d = SQ_KEY1;
               else if (hits.d_exit)            op     = OP_ID_OFF;
            end
            SQ_KEY1: begin
               if (hits.at_key2 && hits.d_key2) step_d = SQ_KEY2;
               else if (hits.d_exit)            op     = OP_ID_OFF;
            end
            SQ_KEY2: begin
               if (hits.at_key1 && hits.d_prog)       step_d = SQ_PROG;
               else if (hits.at_key1 && hits.d_ext)   step_d = SQ_EXT3;
               else if (hits.at_key1 && hits.d_id_on) op     = OP_ID_ON;
               else if (hits.d_exit)                  op     = OP_ID_OFF;
            end
            SQ_PROG: op = OP_PROG;
            SQ_EXT3: begin
               if (hits.at_key1 && hits.d_key1) step_d = SQ_EXT4;
               else if (hits.d_exit)            op     = OP_ID_OFF;
            end
            SQ_EXT4: begin
               if (hits.at_key2 && hits.d_key2) step_d = SQ_EXT5;
               else if (hits.d_exit)            op     = OP_ID_OFF;
            end
            SQ_EXT5: begin
               if (hits.at_key1 && hits.d_chip)      op = OP_CHIP;
               else if (hits.d_sect)                 op = OP_SECT;
               else if (hits.at_key1 && hits.d_lock) op = OP_LOCK;
               else if (hits.d_exit)                 op = OP_ID_OFF;
            end
            default: step_d = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= SQ_IDLE;
      else        step_q <= step_d;
   end
endmodule

// File: rtl/op_launch.sv
module op_launch
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  op_kind_t          op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              prog_go,
   output logic              sect_erase_go,
   output logic              chip_erase_go,
   output logic              lock_go,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   output logic              id_mode
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_go       <= 1'b0;
         sect_erase_go <= 1'b0;
         chip_erase_go <= 1'b0;
         lock_go       <= 1'b0;
         op_addr       <= '0;
         op_data       <= '0;
         id_mode       <= 1'b0;
      end else begin
         prog_go       <= (op == OP_PROG);
         sect_erase_go <= (op == OP_SECT);
         chip_erase_go <= (op == OP_CHIP);
         lock_go       <= (op == OP_LOCK);
         if (op == OP_PROG || op == OP_SECT) begin
            op_addr <= addr;
            op_data <= data;
         end
         if (op == OP_ID_ON)       id_mode <= 1'b1;
         else if (op == OP_ID_OFF) id_mode <= 1'b0;
      end
   end
endmodule

// File: rtl/id_readout.sv
module id_readout #(
   parameter int          ADDR_W     = 17,
   parameter int          ID_W       = 8,
   parameter logic [7:0]  MFR_CODE   = 8'h3C,
   parameter logic [7:0]  DEV_CODE   = 8'hA5,
   parameter bit          ID_REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              id_mode,
   input  logic              lock_status,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [ID_W-1:0]   id_data
);
   logic [ID_W-1:0] sel;

   always_comb begin
      sel = '0;
      if (id_mode) begin
         if (rd_addr == ADDR_W'(0))      sel = ID_W'(MFR_CODE);
         else if (rd_addr == ADDR_W'(1)) sel = ID_W'(DEV_CODE);
         else if (rd_addr == ADDR_W'(2)) sel = ID_W'(lock_status);
      end
   end

   generate
      if (ID_REG_OUT) begin : g_reg
         logic [ID_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= sel;
         end
         assign id_data = q;
      end else begin : g_comb
         assign id_data = sel;
      end
   endgenerate
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import flash_cmd_pkg::*;
#(
   parameter int          ADDR_W     = 17,
   parameter int          DATA_W     = 16,
   parameter int          CMP_ADDR_W = 16,
   parameter int          CMP_DATA_W = 8,
   parameter int          ID_W       = 8,
   parameter logic [7:0]  MFR_CODE   = 8'h3C,
   parameter logic [7:0]  DEV_CODE   = 8'hA5,
   parameter bit          ID_REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy,
   input  logic              lock_status,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              prog_go,
   output logic              sect_erase_go,
   output logic              chip_erase_go,
   output logic              lock_go,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   output logic              id_mode,
   output logic [ID_W-1:0]   id_data
);
   localparam int KEY_ADDR_BITS = 15;

   generate
      if (CMP_ADDR_W > ADDR_W) begin : g_err_aw
         $error("CMP_ADDR_W exceeds ADDR_W");
      end
      if (CMP_ADDR_W < KEY_ADDR_BITS) begin : g_err_kw
         $error("CMP_ADDR_W too narrow for unlock addresses");
      end
      if (CMP_DATA_W > DATA_W || CMP_DATA_W < 8) begin : g_err_dw
         $error("CMP_DATA_W out of range");
      end
      if (ID_W < 8) begin : g_err_iw
         $error("ID_W must hold an 8-bit code");
      end
   endgenerate

   cmd_hits_t hits;
   op_kind_t  op;
   logic      accept;

   assign accept = wr_valid && !busy;

   cmd_matcher #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .CMP_ADDR_W(CMP_ADDR_W), .CMP_DATA_W(CMP_DATA_W)
   ) u_match (
      .addr(wr_addr), .data(wr_data), .hits(hits)
   );

   cmd_sequencer u_seq (
      .clk(clk), .rst_n(rst_n), .accept(accept), .hits(hits), .op(op)
   );

   op_launch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_launch (
      .clk(clk), .rst_n(rst_n), .op(op),
      .addr(wr_addr), .data(wr_data),
      .prog_go(prog_go), .sect_erase_go(sect_erase_go),
      .chip_erase_go(chip_erase_go), .lock_go(lock_go),
      .op_addr(op_addr), .op_data(op_data), .id_mode(id_mode)
   );

   id_readout #(
      .ADDR_W(ADDR_W), .ID_W(ID_W), .MFR_CODE(MFR_CODE),
      .DEV_CODE(DEV_CODE), .ID_REG_OUT(ID_REG_OUT)
   ) u_id (
      .clk(clk), .rst_n(rst_n), .id_mode(id_mode),
      .lock_status(lock_status), .rd_addr(rd_addr), .id_data(id_data)
   );
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
   parameter int ID_W       = 8,
   parameter bit ID_REG_OUT = 1'b0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_valid,
   input logic            busy,
   input logic            prog_go,
   input logic            sect_erase_go,
   input logic            chip_erase_go,
   input logic            lock_go,
   input logic            id_mode,
   input logic [ID_W-1:0] id_data
);
   logic any_go;
   assign any_go = prog_go | sect_erase_go | chip_erase_go | lock_go;

   // R12
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_go, sect_erase_go, chip_erase_go, lock_go}));

   // R12
   short_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_go |=> !any_go);

   // R10
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !any_go);

   // R10
   busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(id_mode));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |=> (!any_go && $stable(id_mode)));

   generate
      if (!ID_REG_OUT) begin : g_comb_chk
         // R11
         id_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !id_mode |-> (id_data == '0));
      end
   endgenerate
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ID_W(ID_W), .ID_REG_OUT(ID_REG_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .busy(busy),
   .prog_go(prog_go), .sect_erase_go(sect_erase_go),
   .chip_erase_go(chip_erase_go), .lock_go(lock_go),
   .id_mode(id_mode), .id_data(id_data)
);

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
   localparam int AW = 17;
   localparam int DW = 16;
   localparam logic [7:0] MFR = 8'h3C;
   localparam logic [7:0] DEV = 8'hA5;
   localparam int K_NONE = 0, K_PROG = 1, K_SECT = 2, K_CHIP = 3, K_LOCK = 4;

   logic clk = 1'b0, rst_n = 1'b0, wr_valid = 1'b0, busy = 1'b0, lock_status = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic prog_go, sect_erase_go, chip_erase_go, lock_go, id_mode;
   logic [AW-1:0] op_addr;
   logic [DW-1:0] op_data;
   logic [7:0] id_data;

   always #2 clk = ~clk;

   flash_cmd_decoder dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .lock_status(lock_status), .rd_addr(rd_addr),
      .prog_go(prog_go), .sect_erase_go(sect_erase_go), .chip_erase_go(chip_erase_go),
      .lock_go(lock_go), .op_addr(op_addr), .op_data(op_data),
      .id_mode(id_mode), .id_data(id_data)
   );

   typedef struct {
      int            kind;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic          idm;
      string         req;
   } item_t;

   item_t q[$];
   item_t e;
   int vectors = 0, fails = 0, got;
   logic chk_due = 1'b0;
   bit done = 0;

   always @(posedge clk) chk_due <= wr_valid && rst_n;

   // monitor: pops one expected item per write
   always @(negedge clk) begin
      if (chk_due && !done) begin
         vectors++;
         got = ({prog_go, sect_erase_go, chip_erase_go, lock_go} == 4'b0) ? K_NONE :
               ({prog_go, sect_erase_go, chip_erase_go, lock_go} == 4'b1000) ? K_PROG :
               ({prog_go, sect_erase_go, chip_erase_go, lock_go} == 4'b0100) ? K_SECT :
               ({prog_go, sect_erase_go, chip_erase_go, lock_go} == 4'b0010) ? K_CHIP :
               ({prog_go, sect_erase_go, chip_erase_go, lock_go} == 4'b0001) ? K_LOCK : 9;
         if (q.size() == 0) begin
            fails++;
            $display("FAIL R12 unexpected result: strobe kind %0d expected none queued", got);
         end else begin
            e = q.pop_front();
            if (got != e.kind || id_mode != e.idm ||
                ((e.kind == K_PROG || e.kind == K_SECT) && op_addr != e.a) ||
                (e.kind == K_PROG && op_data != e.d)) begin
               fails++;
               $display("FAIL %s: kind=%0d idm=%0b addr=%h data=%h expected kind=%0d idm=%0b addr=%h data=%h",
                        e.req, got, id_mode, op_addr, op_data, e.kind, e.idm, e.a, e.d);
            end
         end
      end
   end

   // driver: applies one write and queues its expected outcome
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input int k, input logic idm, input string req);
      item_t it;
      it.kind = k; it.a = a; it.d = d; it.idm = idm; it.req = req;
      q.push_back(it);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic unlock(input logic idm, input string req);
      wr(17'h05555, 16'h00AA, K_NONE, idm, req);
      wr(17'h02AAA, 16'h0055, K_NONE, idm, req);
   endtask

   task automatic ext_prefix(input logic idm, input string req);
      unlock(idm, req);
      wr(17'h05555, 16'h0080, K_NONE, idm, req);
      unlock(idm, req);
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({31'd0, id_mode}, 0, "R1 id_mode after reset");
      chk({28'd0, prog_go, sect_erase_go, chip_erase_go, lock_go}, 0, "R1 strobes after reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk({31'd0, id_mode}, 0, "R1 id_mode after release");
      // R1 no pending sequence: A0 alone then data launches nothing
      wr(17'h05555, 16'h00A0, K_NONE, 0, "R1");
      wr(17'h01234, 16'h5678, K_NONE, 0, "R1");
      // R2 word program
      unlock(0, "R2");
      wr(17'h05555, 16'h00A0, K_NONE, 0, "R2");
      wr(17'h12345, 16'hBEEF, K_PROG, 0, "R2");
      // R3 chip erase
      ext_prefix(0, "R3");
      wr(17'h05555, 16'h0010, K_CHIP, 0, "R3");
      // R4 sector erase
      ext_prefix(0, "R4");
      wr(17'h03123, 16'h0030, K_SECT, 0, "R4");
      // R5 lockout enable
      ext_prefix(0, "R5");
      wr(17'h05555, 16'h0040, K_LOCK, 0, "R5");
      // R6 id entry and readout R11
      unlock(0, "R6");
      wr(17'h05555, 16'h0090, K_NONE, 1, "R6");
      lock_status = 1'b1;
      rd_addr = 17'h0; #1 chk({24'd0, id_data}, {24'd0, MFR}, "R11 manufacturer");
      rd_addr = 17'h1; #1 chk({24'd0, id_data}, {24'd0, DEV}, "R11 device");
      rd_addr = 17'h2; #1 chk({24'd0, id_data}, 32'h1, "R11 lock status");
      rd_addr = 17'h3; #1 chk({24'd0, id_data}, 0, "R11 other address");
      // R7 same-cycle case: F0 as program data in id mode keeps id mode
      unlock(1, "R7");
      wr(17'h05555, 16'h00A0, K_NONE, 1, "R7");
      wr(17'h00777, 16'h00F0, K_PROG, 1, "R7");
      // R6 three-cycle exit
      unlock(1, "R6");
      wr(17'h05555, 16'h00F0, K_NONE, 0, "R6");
      rd_addr = 17'h0; #1 chk({24'd0, id_data}, 0, "R11 array mode");
      // R7 lone F0 anywhere
      unlock(0, "R7");
      wr(17'h05555, 16'h0090, K_NONE, 1, "R7");
      wr(17'h1ABCD, 16'h00F0, K_NONE, 0, "R7");
      // R7 F0 mid-prefix aborts: erase sixth write then does nothing
      unlock(0, "R7");
      wr(17'h05555, 16'h0090, K_NONE, 1, "R7");
      unlock(1, "R7");
      wr(17'h05555, 16'h0080, K_NONE, 1, "R7");
      wr(17'h05555, 16'h00F0, K_NONE, 0, "R7");
      wr(17'h02AAA, 16'h0055, K_NONE, 0, "R7");
      wr(17'h05555, 16'h0010, K_NONE, 0, "R7");
      // R8 mismatch aborts
      wr(17'h05555, 16'h00AA, K_NONE, 0, "R8");
      wr(17'h02AAA, 16'h0054, K_NONE, 0, "R8");
      wr(17'h05555, 16'h00A0, K_NONE, 0, "R8");
      wr(17'h04444, 16'h1111, K_NONE, 0, "R8");
      wr(17'h05555, 16'h00AA, K_NONE, 0, "R8");
      wr(17'h02AAB, 16'h0055, K_NONE, 0, "R8");
      wr(17'h05555, 16'h0090, K_NONE, 0, "R8");
      // R9 upper address and data bits ignored
      wr(17'h15555, 16'hFFAA, K_NONE, 0, "R9");
      wr(17'h12AAA, 16'h1255, K_NONE, 0, "R9");
      wr(17'h15555, 16'h77A0, K_NONE, 0, "R9");
      wr(17'h00042, 16'hCAFE, K_PROG, 0, "R9");
      // R10 busy freezes everything
      unlock(0, "R10");
      busy = 1'b1;
      wr(17'h05555, 16'h0090, K_NONE, 0, "R10");
      wr(17'h01111, 16'h00F0, K_NONE, 0, "R10");
      busy = 1'b0;
      wr(17'h05555, 16'h00A0, K_NONE, 0, "R10");
      wr(17'h00999, 16'h4321, K_PROG, 0, "R10");
      repeat (3) @(negedge clk);
      chk(q.size(), 0, "R12 all expected results seen");
      finish_run();
   end
endmodule